// File: doc/BRIEF.md
# Backlight Current Fade Ramp Generator

This block produces the 8-bit current codes and the sink-enable signals for two backlight current sinks, called MAIN and SUB. Each code maps to sink current in 0.1 mA units, so code 0 is 0 mA and code 255 is 25.5 mA. Software writes a target code per channel. With fading off, a written code is applied on the next clock. With fading on, the channel chosen by a select bit walks one LSB at a time from its present value toward the target.

The pace of the walk comes from a slope bit. Each value of the bit selects a step interval in clock cycles. The defaults give about 0.65 s (slope 0) or 1.3 s (slope 1) for a full 0-to-255 sweep at a 1 MHz clock. A smaller change therefore finishes in proportionally less time. A tie bit makes SUB reuse the MAIN code, enable and PWM gate, so that one code drives both sinks.

Each sink is switched on only when its enable is set. When its external-PWM enable is also set, the sink is further gated by an active-high PWM input.

Top module: `bl_fade_ramp`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both code outputs are 0, `busy` is low and both sink enables are low, given all control inputs at 0.
- R2: A channel that is not being faded applies its written code one clock edge after the write. Clearing `fade_en` in the middle of a ramp jumps to the target on the next edge.
- R3: A faded channel changes by exactly one LSB toward its target per step. The k-th step lands k×FAST_DIV edges after the write when `slope` is 0, and k×SLOW_DIV edges after the write when `slope` is 1.
- R4: A full-scale ramp from 0 to 255 ends exactly 255×FAST_DIV edges after the write, with the code at 254 one edge earlier.
- R5: A new target written in the middle of a ramp is approached from the present code with no jump, keeping the same step timing.
- R6: `fade_sel` = 0 fades MAIN and `fade_sel` = 1 fades SUB. The other channel follows its code immediately.
- R7: With `disp_tie` = 1, `sub_level` equals `main_level`. SUB is then gated by `main_en`, `main_pwm_en` and `pwm_in`. A MAIN fade therefore appears on both outputs.
- R8: A sink whose enable bit is 0 has its on output low whatever its code and PWM state.
- R9: A sink with its PWM enable set is on only while `pwm_in` is high. With its PWM enable clear, `pwm_in` has no effect on it.
- R10: `busy` is high exactly while `main_level` differs from `main_code`, or, when not tied, while `sub_level` differs from `sub_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_code | input | CODE_W | Target current code for MAIN |
| sub_code | input | CODE_W | Target current code for SUB |
| fade_en | input | 1 | Enable ramping |
| fade_sel | input | 1 | 0 ramps MAIN, 1 ramps SUB |
| slope | input | 1 | 0 selects FAST_DIV, 1 selects SLOW_DIV cycles per step |
| disp_tie | input | 1 | SUB uses the MAIN code and gating |
| main_en | input | 1 | MAIN sink enable |
| sub_en | input | 1 | SUB sink enable |
| main_pwm_en | input | 1 | Gate MAIN with pwm_in |
| sub_pwm_en | input | 1 | Gate SUB with pwm_in |
| pwm_in | input | 1 | External PWM, active high |
| main_level | output | CODE_W | Applied MAIN code |
| sub_level | output | CODE_W | Applied SUB code |
| main_on | output | 1 | MAIN sink enable out |
| sub_on | output | 1 | SUB sink enable out |
| busy | output | 1 | Applied code differs from target |

## Verification
A faulty step counter shows up as a level that reaches its target too early or too late. The bench therefore samples one edge before and exactly at the computed arrival edge, so an off-by-one in the interval is caught on the first step of any ramp. A wrong direction or step size shows on the next step edge as a level that moves away from, or past, the target. A stale applied code after a retarget or after a fade-disable is visible one edge later as a jump, or a missing jump, on `main_level`. Gating errors are combinational and appear at once on `main_on`/`sub_on`.

// File: rtl/bl_fade_ramp.sv
module bl_fade_ramp #(
  parameter int CODE_W   = 8,
  parameter int FAST_DIV = 2549,
  parameter int SLOW_DIV = 5098
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] main_code,
  input  logic [CODE_W-1:0] sub_code,
  input  logic              fade_en,
  input  logic              fade_sel,
  input  logic              slope,
  input  logic              disp_tie,
  input  logic              main_en,
  input  logic              sub_en,
  input  logic              main_pwm_en,
  input  logic              sub_pwm_en,
  input  logic              pwm_in,
  output logic [CODE_W-1:0] main_level,
  output logic [CODE_W-1:0] sub_level,
  output logic              main_on,
  output logic              sub_on,
  output logic              busy
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV + 1);

  logic [CODE_W-1:0] main_cur, sub_cur, r_cur, r_tgt, r_next;
  logic [CNT_W-1:0]  cnt, lim;
  logic              ramping, tick, ramp_main, ramp_sub;

  assign ramp_main = fade_en & ~fade_sel;
  assign ramp_sub  = fade_en &  fade_sel;
  assign r_cur     = fade_sel ? sub_cur  : main_cur;
  assign r_tgt     = fade_sel ? sub_code : main_code;
  assign ramping   = fade_en && (r_cur != r_tgt);
  assign lim       = slope ? CNT_W'(SLOW_DIV - 1) : CNT_W'(FAST_DIV - 1);
  assign tick      = ramping && (cnt >= lim);
  assign r_next    = (r_cur < r_tgt) ? r_cur + 1'b1 : r_cur - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      main_cur <= '0;
      sub_cur  <= '0;
    end else begin
      if (!ramping || tick) cnt <= '0;
      else                  cnt <= cnt + 1'b1;

      if (!ramp_main)  main_cur <= main_code;
      else if (tick)   main_cur <= r_next;

      if (!ramp_sub)   sub_cur <= sub_code;
      else if (tick)   sub_cur <= r_next;
    end
  end

  assign main_level = main_cur;
  assign sub_level  = disp_tie ? main_cur : sub_cur;
  assign main_on    = main_en & (~main_pwm_en | pwm_in);
  assign sub_on     = disp_tie ? main_on : (sub_en & (~sub_pwm_en | pwm_in));
  assign busy       = (main_cur != main_code) | (~disp_tie & (sub_cur != sub_code));
endmodule

// File: rtl/bl_fade_ramp_chk.sv
module bl_fade_ramp_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] main_code,
  input logic              fade_en,
  input logic              fade_sel,
  input logic              disp_tie,
  input logic              main_en,
  input logic              sub_en,
  input logic [CODE_W-1:0] main_level,
  input logic [CODE_W-1:0] sub_level,
  input logic              main_on,
  input logic              sub_on,
  input logic              busy
);
  assert_direct_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(fade_en)) |-> (main_level == $past(main_code)));

  assert_single_lsb_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fade_en) && !$past(fade_sel)) |->
      (main_level == $past(main_level) ||
       main_level == $past(main_level) + 1'b1 ||
       main_level == $past(main_level) - 1'b1));

  assert_tied_levels_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_tie |-> (sub_level == main_level && sub_on == main_on));

  assert_main_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !main_en |-> !main_on);

  assert_sub_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_en && !disp_tie) |-> !sub_on);

  assert_idle_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (main_level == main_code));
endmodule

bind bl_fade_ramp bl_fade_ramp_chk #(.CODE_W(CODE_W)) chk (.*);

// File: tb/bl_fade_ramp_test.sv
module bl_fade_ramp_test;
  localparam int F = 3;
  localparam int S = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] main_code = '0, sub_code = '0;
  logic       fade_en = 0, fade_sel = 0, slope = 0, disp_tie = 0;
  logic       main_en = 0, sub_en = 0, main_pwm_en = 0, sub_pwm_en = 0, pwm_in = 0;
  logic [7:0] main_level, sub_level;
  logic       main_on, sub_on, busy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bl_fade_ramp #(.CODE_W(8), .FAST_DIV(F), .SLOW_DIV(S)) uut (
    .clk(clk), .rst_n(rst_n), .main_code(main_code), .sub_code(sub_code),
    .fade_en(fade_en), .fade_sel(fade_sel), .slope(slope), .disp_tie(disp_tie),
    .main_en(main_en), .sub_en(sub_en), .main_pwm_en(main_pwm_en),
    .sub_pwm_en(sub_pwm_en), .pwm_in(pwm_in), .main_level(main_level),
    .sub_level(sub_level), .main_on(main_on), .sub_on(sub_on), .busy(busy));

  // {main_en, sub_en, main_pwm_en, sub_pwm_en, pwm_in, disp_tie, exp_main_on, exp_sub_on}
  localparam logic [7:0] VEC [8] = '{
    8'b110000_11,  // R9 pwm ignored when gate off
    8'b111000_01,  // R9 main gated, pwm low
    8'b111110_11,  // R9 both gated, pwm high
    8'b110100_10,  // R9 sub gated, pwm low
    8'b010010_01,  // R8 main disabled
    8'b100010_10,  // R8 sub disabled
    8'b010001_00,  // R7 tie uses main enable
    8'b101011_11   // R7 tie uses main pwm gate
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    check("R1 main_level in reset", main_level, 0);
    check("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    cyc(1);
    check("R1 sub_level after reset", sub_level, 0);
    check("R1 main_on after reset", main_on, 0);

    for (int i = 0; i < 8; i++) begin
      {main_en, sub_en, main_pwm_en, sub_pwm_en, pwm_in, disp_tie} = VEC[i][7:2];
      #1;
      check($sformatf("R8/R9 main_on row %0d", i), main_on, VEC[i][1]);
      check($sformatf("R8/R9 sub_on row %0d", i), sub_on, VEC[i][0]);
    end
    {main_en, sub_en, main_pwm_en, sub_pwm_en, pwm_in, disp_tie} = 6'b110000;
    cyc(1);

    main_code = 8'd200;
    #1 check("R10 busy after unfaded write", busy, 1);
    cyc(1);
    check("R2 immediate apply", main_level, 200);
    check("R10 busy clears", busy, 0);

    fade_en = 1; main_code = 8'd210;
    cyc(F * 10 - 1);
    check("R3 slope0 one step short", main_level, 209);
    check("R10 busy while ramping", busy, 1);
    cyc(1);
    check("R3 slope0 arrival", main_level, 210);

    slope = 1; main_code = 8'd205;
    cyc(S * 5 - 1);
    check("R3 slope1 one step short", main_level, 206);
    cyc(1);
    check("R3 slope1 arrival", main_level, 205);
    slope = 0;

    main_code = 8'd215;
    cyc(F * 3);
    check("R5 before retarget", main_level, 208);
    main_code = 8'd200;
    cyc(1);
    check("R5 no jump on retarget", main_level, 208);
    cyc(F * 8 - 2);
    check("R5 one step short", main_level, 201);
    cyc(1);
    check("R5 arrival", main_level, 200);

    fade_sel = 1; main_code = 8'd100; sub_code = 8'd4;
    cyc(1);
    check("R6 main immediate when sub faded", main_level, 100);
    check("R6 sub not yet stepped", sub_level, 0);
    cyc(F * 4 - 2);
    check("R6 sub one step short", sub_level, 3);
    cyc(1);
    check("R6 sub arrival", sub_level, 4);

    fade_sel = 0; disp_tie = 1; main_code = 8'd104;
    cyc(F * 2);
    check("R7 tied sub follows main ramp", sub_level, 102);
    check("R7 main ramp", main_level, 102);
    cyc(F * 2);
    check("R7 tied arrival", sub_level, 104);
    disp_tie = 0;

    fade_en = 0; main_code = 8'd0;
    cyc(1);
    fade_en = 1; main_code = 8'd255;
    cyc(F * 255 - 1);
    check("R4 full scale one step short", main_level, 254);
    check("R10 busy at 254", busy, 1);
    cyc(1);
    check("R4 full scale arrival", main_level, 255);
    check("R10 busy idle at target", busy, 0);

    main_code = 8'd0;
    cyc(F * 10);
    check("R3 ramp down", main_level, 245);
    fade_en = 0;
    cyc(1);
    check("R2 fade off mid ramp jumps", main_level, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule